// File: doc/BRIEF.md
# Memory-to-Memory Instruction Executor

This block is a small multi-cycle processor core with no program counter and no registers that software can see. An external controller presents one 16-bit instruction and pulses `start` while `ready` is high. The core then runs a short series of memory reads and writes on a 16-word by 4-bit RAM outside the block, and raises `ready` again when it is done. Each instruction reads from that RAM and writes back to it. Nothing is kept from one instruction to the next.

The instruction carries four 4-bit fields. The top field selects the operation, and the other three name memory addresses or small literals. Reads are combinational: the RAM drives `mem_rdata` from `mem_addr` in the same cycle. A write commits on the clock edge that ends a cycle in which `mem_wen` is high. Internally a sequencer steps through up to two read cycles and one write cycle. A single scratch latch holds the first operand, and a combinational function unit computes the value to store.

Top module: `mm_exec_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ready` is 1, `mem_wen` is 0, and `mem_addr` and `mem_wdata` are 0.
- R2: The instruction fields are: opcode in bits 15..12, field A in bits 11..8, field B in bits 7..4, field C in bits 3..0. An instruction is launched when `start` is 1 at a rising edge while `ready` is 1. `ready` is 0 from the next cycle until the instruction ends.
- R3: Opcode 3 stores the literal value A at address C. The write cycle is the first cycle after launch, and `ready` returns on the cycle after that. For example, 0x3803 stores 8 at address 3.
- R4: Opcode 1 copies M[A] to M[C]. Opcode 2 stores M[A]+B (modulo 16) to M[C]. Opcode 4 stores M[A] shifted right by one, with a zero into the top bit. For these three opcodes, cycle 1 after launch reads address A, cycle 2 writes, and `ready` is low for exactly 2 cycles.
- R5: Opcode 5 stores M[A]+M[B] and opcode 6 stores M[A]-M[B], both modulo 16, to M[C]. Cycle 1 reads A, cycle 2 reads B, cycle 3 writes, and `ready` is low for exactly 3 cycles.
- R6: Opcode 7 stores M[B] to M[C] only when M[A] is 0. Otherwise it takes the same three cycles with `mem_wen` held low, and memory is left unchanged.
- R7: Opcode 8 compares M[A] and M[B] as unsigned values. It stores 0 to M[C] when M[A] < M[B] and stores 1 otherwise, including when the two are equal.
- R8: Opcode 0 and opcodes 9 to 15 write nothing and keep `ready` low for exactly one cycle.
- R9: A `start` pulse that arrives while `ready` is low has no effect. The running instruction finishes unchanged and is not repeated.
- R10: `mem_wen` is 1 only in the write cycle. In that cycle `mem_addr` equals C and `mem_wdata` holds the result. `mem_addr` shows A or B in the read cycles and 0 in every other cycle. `mem_wdata` is 0 outside the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse |
| instr | input | 16 | Instruction; held stable until `ready` returns |
| ready | output | 1 | High while idle and able to accept an instruction |
| mem_addr | output | 4 | RAM word address |
| mem_rdata | input | 4 | RAM read data for `mem_addr`, same cycle |
| mem_wdata | output | 4 | RAM write data |
| mem_wen | output | 1 | RAM write enable |

## Verification
All outputs are registered, so the first effect of a launch edge shows on the cycle after it. The write lands on the 1st, 2nd or 3rd cycle after launch, depending on the opcode class, and `ready` rises on the cycle after the write. The bench's model builds the expected per-cycle output list at the launch edge and pops one entry on every rising edge. It compares `ready`, `mem_wen`, `mem_addr` and `mem_wdata` at each falling edge, so every result is checked in exactly the cycle it is due. It also checks final RAM words against hand-computed values, and counts the busy cycles of each instruction.

// File: rtl/mm_exec_pkg.sv
package mm_exec_pkg;

  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_WR,
    ST_DONE
  } seq_st_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_A_ONLY,
    RD_AB
  } rd_need_t;

  localparam logic [OP_W-1:0] OPC_NOP  = 4'd0;
  localparam logic [OP_W-1:0] OPC_COPY = 4'd1;
  localparam logic [OP_W-1:0] OPC_ADDI = 4'd2;
  localparam logic [OP_W-1:0] OPC_LIT  = 4'd3;
  localparam logic [OP_W-1:0] OPC_SHR  = 4'd4;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'd5;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'd6;
  localparam logic [OP_W-1:0] OPC_CMOV = 4'd7;
  localparam logic [OP_W-1:0] OPC_SLT  = 4'd8;

  // How many memory operands an opcode fetches before its write.
  function automatic rd_need_t rd_need(input logic [OP_W-1:0] op);
    case (op)
      OPC_COPY, OPC_ADDI, OPC_SHR:          return RD_A_ONLY;
      OPC_ADD, OPC_SUB, OPC_CMOV, OPC_SLT:  return RD_AB;
      default:                              return RD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mm_seq_ctrl.sv
module mm_seq_ctrl
  import mm_exec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] op,
  output seq_st_t         st,
  output seq_st_t         nxt,
  output logic            ready
);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          if (rd_need(op) == RD_NONE) nxt = (op == OPC_LIT) ? ST_WR : ST_DONE;
          else                        nxt = ST_RDA;
        end
      end
      ST_RDA:  nxt = (rd_need(op) == RD_AB) ? ST_RDB : ST_WR;
      ST_RDB:  nxt = ST_WR;
      ST_WR:   nxt = ST_IDLE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ready <= 1'b1;
    end else begin
      st    <= nxt;
      ready <= (nxt == ST_IDLE);
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> (ready && st == ST_IDLE));

  // R2
  launch_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready);

  // R9
  rda_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDA) |-> ($past(st) == ST_IDLE));

  // R8
  done_short_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) |=> ready);

endmodule

// File: rtl/mm_operand_latch.sv
module mm_operand_latch #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

endmodule

// File: rtl/mm_func_unit.sv
module mm_func_unit
  import mm_exec_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic [ADDR_W-1:0] fld_a,
  input  logic [ADDR_W-1:0] fld_b,
  output logic [DATA_W-1:0] res,
  output logic              wr_ok
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] imm_a, imm_b;
  assign imm_a = DATA_W'(fld_a);
  assign imm_b = DATA_W'(fld_b);

  always_comb begin
    res   = '0;
    wr_ok = 1'b1;
    case (op)
      OPC_COPY: res = a_val;
      OPC_ADDI: res = a_val + imm_b;
      OPC_LIT:  res = imm_a;
      OPC_SHR:  res = a_val >> 1;
      OPC_ADD:  res = a_val + b_val;
      OPC_SUB:  res = a_val - b_val;
      OPC_CMOV: begin
        res   = b_val;
        wr_ok = (a_val == '0);
      end
      OPC_SLT:  res = (a_val < b_val) ? '0 : ONE;
      default:  wr_ok = 1'b0;
    endcase
  end

  // R7
  always_comb begin
    if (op == OPC_SLT) slt_range_chk: assert (res <= ONE);
  end

endmodule

// File: rtl/mm_exec_top.sv
module mm_exec_top
  import mm_exec_pkg::*;
#(
  parameter  int DATA_W  = 4,
  parameter  int ADDR_W  = 4,
  localparam int INSTR_W = OP_W + 3 * ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  output logic               ready,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_wen
);

  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] fld_a, fld_b, fld_c;

  assign op    = instr[INSTR_W-1 -: OP_W];
  assign fld_a = instr[3*ADDR_W-1 -: ADDR_W];
  assign fld_b = instr[2*ADDR_W-1 -: ADDR_W];
  assign fld_c = instr[ADDR_W-1:0];

  seq_st_t st, nxt;

  mm_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .op    (op),
    .st    (st),
    .nxt   (nxt),
    .ready (ready)
  );

  logic [DATA_W-1:0] a_q, a_val, res;
  logic              wr_ok;

  mm_operand_latch #(.DATA_W(DATA_W)) u_alatch (
    .clk (clk),
    .rst (rst),
    .ld  (st == ST_RDA),
    .d   (mem_rdata),
    .q   (a_q)
  );

  // One-operand ops compute straight from the bus in their read cycle.
  assign a_val = (st == ST_RDA) ? mem_rdata : a_q;

  mm_func_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fu (
    .op    (op),
    .a_val (a_val),
    .b_val (mem_rdata),
    .fld_a (fld_a),
    .fld_b (fld_b),
    .res   (res),
    .wr_ok (wr_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wen   <= 1'b0;
    end else begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wen   <= 1'b0;
      case (nxt)
        ST_RDA: mem_addr <= fld_a;
        ST_RDB: mem_addr <= fld_b;
        ST_WR: begin
          mem_addr  <= fld_c;
          mem_wdata <= res;
          mem_wen   <= wr_ok;
        end
        default: ;
      endcase
    end
  end

  // R10
  wen_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wen |-> (mem_addr == fld_c));

  // R10
  wen_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wen |-> !ready);

  // R3
  wr_then_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR) |=> ready);

  // R5
  rdb_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDB) |-> (mem_addr == fld_b));

endmodule

// File: tb/mm_exec_top_tb_top.sv
`timescale 1ns/1ps
module mm_exec_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        ready, mem_wen;
  logic [3:0]  mem_addr, mem_rdata, mem_wdata;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  mm_exec_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .instr     (instr),
    .ready     (ready),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_wen   (mem_wen)
  );

  // External RAM
  logic [3:0] ram [16];
  always @(posedge clk) begin
    if (rst) for (int i = 0; i < 16; i++) ram[i] <= '0;
    else if (mem_wen) ram[mem_addr] <= mem_wdata;
  end
  assign mem_rdata = ram[mem_addr];

  // Cycle reference model
  typedef struct packed {
    logic       rdy;
    logic       wen;
    logic [3:0] adr;
    logic [3:0] dat;
  } cyc_t;

  cyc_t       exp_q[$];
  cyc_t       exp_c;
  logic [3:0] ref_mem [16];

  task automatic plan(input logic [15:0] ins);
    logic [3:0] op, fa, fb, fc, ma, mb;
    op = ins[15:12]; fa = ins[11:8]; fb = ins[7:4]; fc = ins[3:0];
    ma = ref_mem[fa]; mb = ref_mem[fb];
    case (op)
      4'd1: begin exp_q.push_back('{1'b0,1'b0,fa,4'd0}); exp_q.push_back('{1'b0,1'b1,fc,ma}); end
      4'd2: begin exp_q.push_back('{1'b0,1'b0,fa,4'd0}); exp_q.push_back('{1'b0,1'b1,fc,4'(ma+fb)}); end
      4'd3: exp_q.push_back('{1'b0,1'b1,fc,fa});
      4'd4: begin exp_q.push_back('{1'b0,1'b0,fa,4'd0}); exp_q.push_back('{1'b0,1'b1,fc,4'(ma/2)}); end
      4'd5, 4'd6, 4'd7, 4'd8: begin
        logic [3:0] r;
        logic       w;
        w = 1'b1;
        if (op == 4'd5)      r = 4'(ma + mb);
        else if (op == 4'd6) r = 4'(ma - mb);
        else if (op == 4'd7) begin r = mb; w = (ma == 4'd0); end
        else                 r = (ma < mb) ? 4'd0 : 4'd1;
        exp_q.push_back('{1'b0,1'b0,fa,4'd0});
        exp_q.push_back('{1'b0,1'b0,fb,4'd0});
        exp_q.push_back('{1'b0,w,fc,r});
      end
      default: exp_q.push_back('{1'b0,1'b0,4'd0,4'd0});
    endcase
    exp_q.push_back('{1'b1,1'b0,4'd0,4'd0});
  endtask

  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete();
      exp_c = '{1'b1,1'b0,4'd0,4'd0};
      for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    end else begin
      if (exp_q.size() == 0 && exp_c.rdy && start) plan(instr);
      if (exp_q.size() != 0) begin
        exp_c = exp_q.pop_front();
        if (exp_c.wen) ref_mem[exp_c.adr] = exp_c.dat;
      end
    end
  end

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      compared++;
      if ({ready, mem_wen, mem_addr, mem_wdata} !== exp_c) begin
        mismatched++;
        $display("FAIL %s cycle: actual rdy=%0b wen=%0b adr=%0h dat=%0h expected rdy=%0b wen=%0b adr=%0h dat=%0h",
                 (ready !== exp_c.rdy) ? "R2" : "R10",
                 ready, mem_wen, mem_addr, mem_wdata,
                 exp_c.rdy, exp_c.wen, exp_c.adr, exp_c.dat);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic run(input logic [15:0] ins, output int lowc, input bit extra = 1'b0);
    while (!ready) @(negedge clk);
    instr = ins;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lowc  = 0;
    while (!ready) begin
      lowc++;
      start = (extra && lowc == 1);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(ready), 1);
    chk("R1 wen", int'(mem_wen), 0);
    chk("R1 addr", int'(mem_addr), 0);
    chk("R1 wdata", int'(mem_wdata), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 literal
    run(16'h3803, n); chk("R3 m3", int'(ram[3]), 8); chk("R3 busy", n, 1);
    run(16'h3F05, n); chk("R3 m5", int'(ram[5]), 15);
    // R4 single-operand ops
    run(16'h1307, n); chk("R4 copy", int'(ram[7]), 8); chk("R4 busy", n, 2);
    run(16'h2395, n); chk("R4 addi wrap", int'(ram[5]), 1);
    run(16'h4301, n); chk("R4 shr", int'(ram[1]), 4);
    run(16'h3F0E, n);
    run(16'h4E0A, n); chk("R4 shr zero fill", int'(ram[10]), 7);
    // R5 two-operand arithmetic
    run(16'h5E3B, n); chk("R5 add wrap", int'(ram[11]), 7); chk("R5 busy", n, 3);
    run(16'h631C, n); chk("R5 sub", int'(ram[12]), 4);
    run(16'h613D, n); chk("R5 sub borrow", int'(ram[13]), 12);
    // R6 conditional copy
    run(16'h7036, n); chk("R6 taken", int'(ram[6]), 8);
    run(16'h7A56, n); chk("R6 not taken", int'(ram[6]), 8); chk("R6 busy", n, 3);
    // R7 compare
    run(16'h8E32, n); chk("R7 greater", int'(ram[2]), 1);
    run(16'h390F, n);
    run(16'h813F, n); chk("R7 less", int'(ram[15]), 0);
    run(16'h8334, n); chk("R7 equal", int'(ram[4]), 1);
    // R8 no-ops
    run(16'h0000, n); chk("R8 nop busy", n, 1);
    run(16'h9ABC, n); chk("R8 op9 busy", n, 1); chk("R8 op9 m12", int'(ram[12]), 4);
    run(16'hF123, n); chk("R8 op15 m3", int'(ram[3]), 8);
    // R9 start while busy
    run(16'h2555, n, 1'b1); chk("R9 single add", int'(ram[5]), 6); chk("R9 busy", n, 2);
    @(negedge clk);
    chk("R9 idle after", int'(ready), 1);
    // R10 full memory image
    for (int i = 0; i < 16; i++) chk("R10 memory", int'(ram[i]), int'(ref_mem[i]));
    summary();
    $finish;
  end

endmodule